// File: doc/BRIEF.md
# Handshaked Serial Keyboard Receiver

This block receives the one-way serial stream of a keyboard. The keyboard drives both a clock line and a data line. The block turns each frame into an 8-bit scancode and holds it in a data register. A status flag tells the host that a code is waiting. The acknowledge handshake is a pulse that pulls the data line low. While a code is still unread, the block withholds that pulse, so the keyboard waits and no keystroke is lost. Once the host releases the code, the block sends the pulse. The block discards surplus bits at the end of a frame. It drops a partial frame when the keyboard clock stays idle too long. It also supports a manual resync: the host writes zero to the status register and then writes zero to the data register.

The host side has a one-bit register select, a read strobe, a write strobe, write data and read data. Select 0 is the data register and select 1 is the status register. Read data is combinational while the read strobe is high and is zero otherwise. A read has no side effect. The keyboard data line is open-drain. The block asserts `kb_dat_low_o` to pull it low, and the board combines this with the keyboard's own drive in a wired-AND.

Top module: `kbd_rx_top`

## Requirements
- R1: After reset, the status register reads 0x00, the data register reads 0x00 and `kb_dat_low_o` is 0.
- R2: The keyboard sends the scancode bits in the order 6,5,4,3,2,1,0,7. Each bit is sampled on a rising edge of the keyboard clock and is active-low (line low = 1). The data register shows the code in normal order, so bit 7 of a delivered value is the last bit received. That bit is the key-up flag.
- R3: Status bit 7 becomes 1 when the eighth bit of a frame has been sampled. Status bits 6 to 0 always read 0.
- R4: While a code is pending, `kb_dat_low_o` stays 0. Further keyboard clock edges leave the data register and the status flag unchanged.
- R5: A write of 0x00 to the data register while a code is pending clears status bit 7. In the next cycle `kb_dat_low_o` goes to 1 and stays there for exactly HS_CYCLES cycles. HS_CYCLES is CLK_KHZ*HS_US/1000, rounded up.
- R6: A write of a nonzero value to the data register has no effect. A write of 0x00 to the data register has no effect when no code is pending and no resync is armed. Neither kind of write starts a handshake or disturbs a frame that is partly received.
- R7: Bits received after the eighth bit of a frame are discarded. After the handshake, the next frame decodes correctly.
- R8: A partly received frame (1 to 7 bits) is dropped if IDLE_CYCLES = CLK_KHZ*IDLE_US/1000 (rounded up) cycles pass with no rising edge of the keyboard clock.
- R9: A write of 0x00 to the status register arms a resync. Any later status write of a nonzero value disarms it, and so does any data write. A data write of 0x00 while armed drops any partial frame, clears the status flag and starts a handshake of HS_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| kb_clk_i | input | 1 | Keyboard clock line, asynchronous, idles high |
| kb_dat_i | input | 1 | Keyboard data line as seen on the wire, asynchronous |
| kb_dat_low_o | output | 1 | 1 = pull the keyboard data line low (acknowledge handshake) |
| host_sel_i | input | 1 | Register select: 0 data, 1 status |
| host_rd_i | input | 1 | Host read strobe |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data, valid while the read strobe is high |

## Verification
The frames cover both values of the key-up bit and codes whose bits differ from their neighbours, so a shift in the wrong direction or a missing inversion shows up as a wrong code. Three kinds of irregular frame are tried: one with trailing surplus bits, one cut short and left idle past the timeout, and one cut short and then resynced. Each is followed by a clean frame, so a bit counter that wraps, a timeout that never fires or a resync that leaves stale bits each corrupts a later code. A zero write with nothing pending is placed in the middle of a frame, and a nonzero write is made while a code is pending. The first tells a correct guard apart from one that resyncs on every zero write; the second shows that a nonzero value releases nothing. The handshake line is compared on every cycle against a behavioural model, and the pulse width is measured separately.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;

    localparam int FRAME_BITS = 8;

    typedef logic [FRAME_BITS-1:0] code_t;

    typedef enum logic {
        REG_DATA   = 1'b0,
        REG_STATUS = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic  valid;
        code_t code;
    } frame_t;

    // Serial order is 6..0 then 7; after shifting left the key-up bit
    // sits at position 0, so rotate right by one to restore order.
    function automatic code_t unrotate(input code_t raw);
        return {raw[0], raw[FRAME_BITS-1:1]};
    endfunction

    function automatic int unsigned us_to_cycles(input int unsigned khz,
                                                 input int unsigned us);
        return (khz * us + 999) / 1000;
    endfunction

endpackage

// File: rtl/kbd_rx_sync.sv
module kbd_rx_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= '1;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[g] <= '1;
                    else     stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/kbd_rx_deframe.sv
module kbd_rx_deframe
    import kbd_rx_pkg::*;
#(
    parameter int unsigned IDLE_CYCLES = 250000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   kclk_s,
    input  logic   kdat_s,
    input  logic   hold,
    input  logic   clear,
    input  logic   hs_done,
    output frame_t frame
);
    localparam int CW = $clog2(FRAME_BITS + 1);
    localparam int IW = $clog2(IDLE_CYCLES + 1);
    localparam logic [CW-1:0] FULL     = CW'(FRAME_BITS);
    localparam logic [CW-1:0] LAST     = CW'(FRAME_BITS - 1);
    localparam logic [IW-1:0] IDLE_MAX = IW'(IDLE_CYCLES - 1);

    logic          kclk_prev;
    logic [CW-1:0] cnt_q;
    code_t         shift_q;
    logic [IW-1:0] idle_q;

    logic  rise, take, partial;
    code_t next_shift;

    assign rise       = kclk_s & ~kclk_prev;
    assign take       = rise & ~hold & (cnt_q < FULL);
    assign partial    = (cnt_q != '0) && (cnt_q < FULL);
    assign next_shift = {shift_q[FRAME_BITS-2:0], ~kdat_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            kclk_prev <= 1'b1;
            cnt_q     <= '0;
            shift_q   <= '0;
            idle_q    <= '0;
        end else begin
            kclk_prev <= kclk_s;
            if (clear || hs_done) begin
                cnt_q   <= '0;
                shift_q <= '0;
                idle_q  <= '0;
            end else if (take) begin
                cnt_q   <= cnt_q + CW'(1);
                shift_q <= next_shift;
                idle_q  <= '0;
            end else if (partial) begin
                if (idle_q == IDLE_MAX) begin
                    cnt_q  <= '0;
                    idle_q <= '0;
                end else begin
                    idle_q <= idle_q + IW'(1);
                end
            end else begin
                idle_q <= '0;
            end
        end
    end

    assign frame.valid = take && (cnt_q == LAST);
    assign frame.code  = unrotate(next_shift);

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL);

    // R4
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (hold && !clear && !hs_done) |=> (cnt_q == $past(cnt_q) || cnt_q == '0));

    // R3
    full_from_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cnt_q == FULL) |-> $past(frame.valid));
endmodule

// File: rtl/kbd_rx_handshake.sv
module kbd_rx_handshake #(
    parameter int unsigned HS_CYCLES = 21250
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic low,
    output logic done
);
    localparam int HW = $clog2(HS_CYCLES + 1);
    localparam logic [HW-1:0] LOAD = HW'(HS_CYCLES);

    logic [HW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (start)         cnt_q <= LOAD;
        else if (cnt_q != '0)   cnt_q <= cnt_q - HW'(1);
    end

    assign low  = (cnt_q != '0);
    assign done = (cnt_q == HW'(1));

    // R5
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> low);

    // R5
    end_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(low) |-> $past(done));
endmodule

// File: rtl/kbd_rx_hostregs.sv
module kbd_rx_hostregs
    import kbd_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_sel_e sel,
    input  logic     rd,
    input  logic     wr,
    input  code_t    wdata,
    input  frame_t   frame,
    output code_t    rdata,
    output logic     pending,
    output logic     release_hs,
    output logic     clear
);
    logic  pending_q, arm_q;
    code_t data_q;
    logic  wr_data, wr_stat, zero_wr;

    assign wr_data    = wr && (sel == REG_DATA);
    assign wr_stat    = wr && (sel == REG_STATUS);
    assign zero_wr    = wr_data && (wdata == '0);
    assign release_hs = zero_wr && (pending_q || arm_q);
    assign clear      = zero_wr && arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            arm_q     <= 1'b0;
            data_q    <= '0;
        end else begin
            if (wr_stat)      arm_q <= (wdata == '0);
            else if (wr_data) arm_q <= 1'b0;

            if (release_hs) begin
                pending_q <= 1'b0;
            end else if (frame.valid) begin
                pending_q <= 1'b1;
                data_q    <= frame.code;
            end
        end
    end

    assign pending = pending_q;
    assign rdata   = !rd ? '0 :
                     (sel == REG_STATUS) ? {pending_q, {(FRAME_BITS-1){1'b0}}} : data_q;

    // R3
    pend_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pending_q) |-> $past(frame.valid));

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pending_q && $past(pending_q)) |-> $stable(data_q));

    // R3
    status_low_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && sel == REG_STATUS) |-> (rdata[FRAME_BITS-2:0] == '0));
endmodule

// File: rtl/kbd_rx_top.sv
module kbd_rx_top
    import kbd_rx_pkg::*;
#(
    parameter int unsigned CLK_KHZ     = 250000,
    parameter int unsigned HS_US       = 85,
    parameter int unsigned IDLE_US     = 1000,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       kb_clk_i,
    input  logic       kb_dat_i,
    output logic       kb_dat_low_o,
    input  logic       host_sel_i,
    input  logic       host_rd_i,
    input  logic       host_wr_i,
    input  logic [7:0] host_wdata_i,
    output logic [7:0] host_rdata_o
);
    localparam int unsigned HS_CYCLES   = us_to_cycles(CLK_KHZ, HS_US);
    localparam int unsigned IDLE_CYCLES = us_to_cycles(CLK_KHZ, IDLE_US);

    logic [1:0] lines_s;
    frame_t     frame;
    logic       pending, release_hs, clear, hs_low, hs_done;
    reg_sel_e   sel;

    assign sel = reg_sel_e'(host_sel_i);

    kbd_rx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({kb_clk_i, kb_dat_i}),
        .q   (lines_s)
    );

    kbd_rx_deframe #(.IDLE_CYCLES(IDLE_CYCLES)) u_deframe (
        .clk     (clk),
        .rst     (rst),
        .kclk_s  (lines_s[1]),
        .kdat_s  (lines_s[0]),
        .hold    (hs_low),
        .clear   (clear),
        .hs_done (hs_done),
        .frame   (frame)
    );

    kbd_rx_hostregs u_regs (
        .clk        (clk),
        .rst        (rst),
        .sel        (sel),
        .rd         (host_rd_i),
        .wr         (host_wr_i),
        .wdata      (host_wdata_i),
        .frame      (frame),
        .rdata      (host_rdata_o),
        .pending    (pending),
        .release_hs (release_hs),
        .clear      (clear)
    );

    kbd_rx_handshake #(.HS_CYCLES(HS_CYCLES)) u_hs (
        .clk   (clk),
        .rst   (rst),
        .start (release_hs),
        .low   (hs_low),
        .done  (hs_done)
    );

    assign kb_dat_low_o = hs_low;

    // R4
    no_ack_while_pending_chk: assert property (@(posedge clk) disable iff (rst)
        kb_dat_low_o |-> !pending);

    // R6
    nonzero_keeps_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr_i && !host_sel_i && host_wdata_i != 8'h00 && pending) |=> pending);
endmodule

// File: tb/test_kbd_rx_top.sv
module test_kbd_rx_top;
    localparam int unsigned CLK_KHZ = 1000;
    localparam int unsigned HS_US   = 85;
    localparam int unsigned IDLE_US = 400;
    localparam int HS   = 85;
    localparam int IDLE = 400;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       kb_clk_drv = 1'b1;
    logic       kb_dat_drv = 1'b1;
    logic       kb_dat_i;
    logic       kb_dat_low_o;
    logic       host_sel = 1'b0;
    logic       host_rd = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done_flag = 0;
    int  m_hs = 0;
    bit  m_pending = 0;
    bit  m_arm = 0;

    always #2 clk = ~clk;

    assign kb_dat_i = kb_dat_drv & ~kb_dat_low_o;

    kbd_rx_top #(.CLK_KHZ(CLK_KHZ), .HS_US(HS_US), .IDLE_US(IDLE_US)) i_kbd_rx_top (
        .clk          (clk),
        .rst          (rst),
        .kb_clk_i     (kb_clk_drv),
        .kb_dat_i     (kb_dat_i),
        .kb_dat_low_o (kb_dat_low_o),
        .host_sel_i   (host_sel),
        .host_rd_i    (host_rd),
        .host_wr_i    (host_wr),
        .host_wdata_i (host_wdata),
        .host_rdata_o (host_rdata)
    );

    // Behavioural model of the handshake line, advanced on each clock
    always @(posedge clk) begin
        if (rst) begin
            m_hs = 0; m_pending = 0; m_arm = 0;
        end else begin
            if (m_hs > 0) m_hs = m_hs - 1;
            if (host_wr && !host_sel) begin
                if (host_wdata == 8'h00 && (m_pending || m_arm)) begin
                    m_hs = HS;
                    m_pending = 0;
                end
                m_arm = 0;
            end else if (host_wr && host_sel) begin
                m_arm = (host_wdata == 8'h00);
            end
        end
    end

    // Every-clock comparison of the handshake line (R4, R5, R6, R9)
    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            n_cmp++;
            if (kb_dat_low_o !== (m_hs > 0)) begin
                n_bad++;
                $display("FAIL R5 handshake line at %0t: actual %0b expected %0b",
                         $time, kb_dat_low_o, (m_hs > 0));
            end
        end
    end

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic sel, input logic [7:0] val);
        @(negedge clk);
        host_sel = sel; host_wdata = val; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = 8'h00;
    endtask

    task automatic host_read(input logic sel, output logic [7:0] v);
        @(negedge clk);
        host_sel = sel; host_rd = 1'b1;
        #1 v = host_rdata;
        host_rd = 1'b0;
    endtask

    function automatic logic bit_at(input logic [7:0] code, input int i);
        if (i < 7)       return code[6-i];
        else if (i == 7) return code[7];
        else             return i[0];
    endfunction

    task automatic send_bits(input logic [7:0] code, input int first, input int last);
        for (int i = first; i <= last; i++) begin
            @(negedge clk);
            kb_dat_drv = ~bit_at(code, i);
            repeat (4) @(negedge clk);
            kb_clk_drv = 1'b0;
            repeat (8) @(negedge clk);
            kb_clk_drv = 1'b1;
            repeat (8) @(negedge clk);
        end
        kb_dat_drv = 1'b1;
    endtask

    task automatic measure_hs(input string tag);
        int w = 0;
        while (kb_dat_low_o) begin
            w++;
            @(negedge clk);
        end
        n_cmp++;
        if (w != HS) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, w, HS);
        end
    endtask

    task automatic expect_regs(input string tag, input logic [7:0] st, input logic [7:0] dt);
        logic [7:0] v;
        host_read(1'b1, v);
        check8({tag, " status"}, v, st);
        host_read(1'b0, v);
        check8({tag, " data"}, v, dt);
    endtask

    task automatic release_code(input string tag);
        host_write(1'b0, 8'h00);
        measure_hs(tag);
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state
        expect_regs("R1 reset", 8'h00, 8'h00);
        check8("R1 ack line", {7'b0, kb_dat_low_o}, 8'h00);

        // R2 / R3 basic frame, key-down code
        send_bits(8'h45, 0, 7);
        m_pending = 1;
        expect_regs("R2 R3 frame 45", 8'h80, 8'h45);

        // R4 keyboard keeps clocking while code pending: ignored
        send_bits(8'hC2, 0, 7);
        expect_regs("R4 stall", 8'h80, 8'h45);

        // R6 nonzero data write does not release
        host_write(1'b0, 8'h5A);
        repeat (3) @(negedge clk);
        expect_regs("R6 nonzero write", 8'h80, 8'h45);

        // R5 release and handshake width
        release_code("R5 handshake width");
        host_read(1'b1, v);
        check8("R5 status cleared", v, 8'h00);

        // R2 key-up code (last bit sets MSB)
        send_bits(8'hC5, 0, 7);
        m_pending = 1;
        expect_regs("R2 key-up C5", 8'h80, 8'hC5);
        release_code("R5 second handshake");

        // R7 trailing surplus bits
        send_bits(8'h33, 0, 10);
        m_pending = 1;
        expect_regs("R7 surplus frame", 8'h80, 8'h33);
        release_code("R7 handshake");
        send_bits(8'h81, 0, 7);
        m_pending = 1;
        expect_regs("R7 next frame", 8'h80, 8'h81);
        release_code("R7 handshake 2");

        // R6 zero write with nothing pending and not armed, mid-frame
        send_bits(8'h6E, 0, 3);
        host_write(1'b0, 8'h00);
        host_read(1'b1, v);
        check8("R6 idle zero write status", v, 8'h00);
        send_bits(8'h6E, 4, 7);
        m_pending = 1;
        expect_regs("R6 frame kept", 8'h80, 8'h6E);
        release_code("R6 handshake");

        // R8 idle timeout drops partial frame
        send_bits(8'h17, 0, 2);
        repeat (IDLE + 100) @(negedge clk);
        host_read(1'b1, v);
        check8("R8 no code after timeout", v, 8'h00);
        send_bits(8'h2C, 0, 7);
        m_pending = 1;
        expect_regs("R8 frame after timeout", 8'h80, 8'h2C);
        release_code("R8 handshake");

        // R9 manual resync mid-frame
        send_bits(8'hF0, 0, 4);
        host_write(1'b1, 8'h00);
        host_write(1'b0, 8'h00);
        measure_hs("R9 resync handshake");
        repeat (4) @(negedge clk);
        host_read(1'b1, v);
        check8("R9 status after resync", v, 8'h00);
        send_bits(8'h1D, 0, 7);
        m_pending = 1;
        expect_regs("R9 frame after resync", 8'h80, 8'h1D);
        release_code("R9 handshake");

        // R9 disarm by nonzero status write
        host_write(1'b1, 8'h00);
        host_write(1'b1, 8'h05);
        host_write(1'b0, 8'h00);
        repeat (3) @(negedge clk);
        check8("R9 disarmed no handshake", {7'b0, kb_dat_low_o}, 8'h00);

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule